// File: doc/BRIEF.md
# Splittable Compare-Toggle Timer

This block is a 16-bit up-counter with two compare registers and two toggle outputs. In combined mode it counts as a single 16-bit value. The low byte's carry feeds the high byte, and a full 16-bit compare match flips the high output. In split mode the same storage becomes two independent 8-bit timers. Each half has its own run bit, its own clock choice, its own compare byte, its own clear-on-match option, its own match flag and its own output pin.

Each half chooses its count clock from four prescaled tap enables supplied by the surrounding chip, or from rising edges on an external event pin. The event pin is synchronised inside the block. Software uses a simple 8-bit register bus with eight addresses. Reading the low count byte in combined mode captures the high byte, so a low-then-high read pair yields one coherent 16-bit value. Output levels can be forced by software while the owning timer is not counting.

Top module: `dct_timer`

## Requirements
- R1: After reset all of the following hold: the counter is 0, both compare bytes are 0xFF, control and clock select are 0, both outputs are 0, both flags are 0, and the bus returns those values at their addresses. The addresses are 0 control, 1 clock select, 2 count low, 3 count high, 4 compare low, 5 compare high, 6 output levels, 7 flags.
- R2: With control bit 0 (split) clear, the counter is one 16-bit value. It advances by one on each selected tick while control bit 2 runs it, using clock select bits [6:4], and the carry out of the low byte increments the high byte.
- R3: In combined mode, the tick that makes the 16-bit count equal to {compare high, compare low} has three effects: it toggles the high output, it sets flag bit 1, and it leaves the low output unchanged.
- R4: With control bit 0 set, the two halves count independently. The low half is run by control bit 1 and clocked by select bits [2:0]. The high half is run by control bit 2 and clocked by select bits [6:4]. A low-byte wrap never changes the high byte.
- R5: In split mode, the tick that makes a half equal to its compare byte toggles that half's output and sets its flag: bit 0 for the low half, bit 1 for the high half.
- R6: When the clear bit for the matching timer is set, the matching tick loads 0 instead of the compare value. The clear bit is control bit 3 for the low half, and control bit 4 for the high half or for the 16-bit counter.
- R7: Clock select values 0 to 3 pick tap enable 0 to 3. Values 4 to 7 pick a rising edge of the event pin, which is seen after a two-stage synchroniser.
- R8: In combined mode, a read of address 2 captures the high byte. Address 3 then returns that captured byte, even if the live high byte has since changed. In split mode, address 3 returns the live high byte.
- R9: A write to address 6 loads bit 0 into the low output only while the low half is not counting, and bit 1 into the high output only while the high timer is stopped. In combined mode the low half counts as never counting. The level of an output whose timer is running is left unchanged.
- R10: Writing 1 to a flag bit clears it and writing 0 leaves it alone. A match in the same cycle wins over the clear. The flags drive irqLo and irqHi directly.
- R11: A bus write to a count byte takes effect on that clock edge and wins over a tick in the same cycle.
- R12: With no selected tick, the counter holds its value even while tap enables toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (used for the coherent-read capture) |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register |
| taps | input | 4 | Prescaled tick enables, one cycle wide per tick |
| evtPin | input | 1 | Asynchronous external event input |
| outLo | output | 1 | Low-half toggle output |
| outHi | output | 1 | High-half / 16-bit toggle output |
| irqLo | output | 1 | Low-half match flag |
| irqHi | output | 1 | High-half / 16-bit match flag |

## Verification
The hardest case to reach from the ports is a coherent 16-bit read that straddles a carry. The low byte has to be read just before it wraps, and the high read has to come after the live high byte has already moved on. The stimulus preloads the counter to 0x12FE with the tick enable held high, so the count advances in every cycle. It then starts the counter and reads the low byte in the next cycle. After one idle cycle it reads the high byte, at a point where the live value is already 0x13 and the captured value must still be 0x12. Event counting is reached by driving multi-cycle pulses on the event pin, so that each one survives the synchroniser as exactly one tick.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int BYTE_W      = 8;
  localparam int FULL_W      = 2 * BYTE_W;
  localparam int NUM_TAPS    = 4;
  localparam int TAP_IDX_W   = $clog2(NUM_TAPS);
  localparam int SEL_W       = TAP_IDX_W + 1;
  localparam int ADDR_W      = 3;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_CSEL = 3'd1,
    REG_CNTL = 3'd2,
    REG_CNTH = 3'd3,
    REG_CMPL = 3'd4,
    REG_CMPH = 3'd5,
    REG_OUT  = 3'd6,
    REG_FLAG = 3'd7
  } regAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              split;
    logic              tickLo;
    logic              tickHi;
    logic              clrLo;
    logic              clrHi;
    logic              wrCntLo;
    logic              wrCntHi;
    logic              presetLo;
    logic              presetHi;
    logic [1:0]        presetVal;
    logic [BYTE_W-1:0] wrByte;
    logic [BYTE_W-1:0] cmpLo;
    logic [BYTE_W-1:0] cmpHi;
  } strobe_t;
endpackage

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic [NUM_TAPS-1:0] taps,
  input  logic              evtPin,
  input  logic [FULL_W-1:0] cnt,
  input  logic              outLo,
  input  logic              outHi,
  input  logic              matchLo,
  input  logic              matchHi,
  output strobe_t           st,
  output logic              irqLo,
  output logic              irqHi
);
  logic splitR, runLo, runHi, clrLoR, clrHiR;
  logic [SEL_W-1:0] selLo, selHi;
  logic [BYTE_W-1:0] cmpLoR, cmpHiR, hiShadow;
  logic flagLo, flagHi;
  logic [SYNC_STAGES-1:0] evtSync;
  logic evtPrev, evtTick;
  logic [1:0] rawTick;
  logic [SEL_W-1:0] selArr [2];

  regAddr_e regSel;
  assign regSel = regAddr_e'(addr);

  logic wrCtrl, wrCsel, wrCntL, wrCntH, wrCmpL, wrCmpH, wrOut, wrFlag, rdCntL;
  assign wrCtrl = wrEn && (regSel == REG_CTRL);
  assign wrCsel = wrEn && (regSel == REG_CSEL);
  assign wrCntL = wrEn && (regSel == REG_CNTL);
  assign wrCntH = wrEn && (regSel == REG_CNTH);
  assign wrCmpL = wrEn && (regSel == REG_CMPL);
  assign wrCmpH = wrEn && (regSel == REG_CMPH);
  assign wrOut  = wrEn && (regSel == REG_OUT);
  assign wrFlag = wrEn && (regSel == REG_FLAG);
  assign rdCntL = rdEn && (regSel == REG_CNTL);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      splitR <= 1'b0;
      runLo  <= 1'b0;
      runHi  <= 1'b0;
      clrLoR <= 1'b0;
      clrHiR <= 1'b0;
      selLo  <= '0;
      selHi  <= '0;
      cmpLoR <= '1;
      cmpHiR <= '1;
    end else begin
      if (wrCtrl) begin
        splitR <= wrData[0];
        runLo  <= wrData[1];
        runHi  <= wrData[2];
        clrLoR <= wrData[3];
        clrHiR <= wrData[4];
      end
      if (wrCsel) begin
        selLo <= wrData[SEL_W-1:0];
        selHi <= wrData[4+SEL_W-1:4];
      end
      if (wrCmpL) cmpLoR <= wrData;
      if (wrCmpH) cmpHiR <= wrData;
    end
  end

  // event pin synchroniser and edge detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtSync <= '0;
      evtPrev <= 1'b0;
    end else begin
      evtSync <= {evtSync[SYNC_STAGES-2:0], evtPin};
      evtPrev <= evtSync[SYNC_STAGES-1];
    end
  end
  assign evtTick = evtSync[SYNC_STAGES-1] & ~evtPrev;

  // per-half clock source selection
  assign selArr[0] = selLo;
  assign selArr[1] = selHi;
  for (genvar h = 0; h < 2; h++) begin : g_clkSel
    assign rawTick[h] = selArr[h][SEL_W-1] ? evtTick
                                           : taps[selArr[h][TAP_IDX_W-1:0]];
  end

  // match flags: set wins over write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagLo <= 1'b0;
      flagHi <= 1'b0;
    end else begin
      flagLo <= matchLo | (flagLo & ~(wrFlag & wrData[0]));
      flagHi <= matchHi | (flagHi & ~(wrFlag & wrData[1]));
    end
  end
  assign irqLo = flagLo;
  assign irqHi = flagHi;

  // high byte capture for coherent 16-bit reads
  always_ff @(posedge clk) begin
    if (!rstN)                   hiShadow <= '0;
    else if (rdCntL && !splitR)  hiShadow <= cnt[FULL_W-1:BYTE_W];
  end

  // strobes to the datapath
  always_comb begin
    st           = '0;
    st.split     = splitR;
    st.tickLo    = splitR && runLo && rawTick[0];
    st.tickHi    = runHi && rawTick[1];
    st.clrLo     = clrLoR;
    st.clrHi     = clrHiR;
    st.wrCntLo   = wrCntL;
    st.wrCntHi   = wrCntH;
    st.presetLo  = wrOut && !(splitR && runLo);
    st.presetHi  = wrOut && !runHi;
    st.presetVal = wrData[1:0];
    st.wrByte    = wrData;
    st.cmpLo     = cmpLoR;
    st.cmpHi     = cmpHiR;
  end

  // read mux
  always_comb begin
    rdData = '0;
    unique case (regSel)
      REG_CTRL: rdData = {3'b000, clrHiR, clrLoR, runHi, runLo, splitR};
      REG_CSEL: rdData = {1'b0, selHi, 1'b0, selLo};
      REG_CNTL: rdData = cnt[BYTE_W-1:0];
      REG_CNTH: rdData = splitR ? cnt[FULL_W-1:BYTE_W] : hiShadow;
      REG_CMPL: rdData = cmpLoR;
      REG_CMPH: rdData = cmpHiR;
      REG_OUT:  rdData = {6'b0, outHi, outLo};
      REG_FLAG: rdData = {6'b0, flagHi, flagLo};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/dct_datapath.sv
module dct_datapath
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  output logic [FULL_W-1:0] cnt,
  output logic              outLo,
  output logic              outHi,
  output logic              matchLo,
  output logic              matchHi
);
  logic [BYTE_W-1:0] cntLo, cntHi, cntLoD, cntHiD;
  logic [BYTE_W-1:0] nxtLo, nxtHi;
  logic [FULL_W-1:0] nxtFull;
  logic hitLo, hitHi, hitFull;

  assign nxtLo   = cntLo + 1'b1;
  assign nxtHi   = cntHi + 1'b1;
  assign nxtFull = {cntHi, cntLo} + 1'b1;

  assign hitLo   =  st.split && st.tickLo && (nxtLo == st.cmpLo);
  assign hitHi   =  st.split && st.tickHi && (nxtHi == st.cmpHi);
  assign hitFull = !st.split && st.tickHi && (nxtFull == {st.cmpHi, st.cmpLo});

  always_comb begin
    cntLoD = cntLo;
    cntHiD = cntHi;
    if (st.split) begin
      if (st.tickLo) cntLoD = (hitLo && st.clrLo) ? '0 : nxtLo;
      if (st.tickHi) cntHiD = (hitHi && st.clrHi) ? '0 : nxtHi;
    end else if (st.tickHi) begin
      {cntHiD, cntLoD} = (hitFull && st.clrHi) ? '0 : nxtFull;
    end
    if (st.wrCntLo) cntLoD = st.wrByte;
    if (st.wrCntHi) cntHiD = st.wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
      outLo <= 1'b0;
      outHi <= 1'b0;
    end else begin
      cntLo <= cntLoD;
      cntHi <= cntHiD;
      outLo <= st.presetLo ? st.presetVal[0] : (outLo ^ hitLo);
      outHi <= st.presetHi ? st.presetVal[1] : (outHi ^ (hitHi | hitFull));
    end
  end

  assign cnt     = {cntHi, cntLo};
  assign matchLo = hitLo;
  assign matchHi = hitHi | hitFull;
endmodule

// File: rtl/dct_timer.sv
module dct_timer
  import dct_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wrData,
  output logic [BYTE_W-1:0]   rdData,
  input  logic [NUM_TAPS-1:0] taps,
  input  logic                evtPin,
  output logic                outLo,
  output logic                outHi,
  output logic                irqLo,
  output logic                irqHi
);
  strobe_t           st;
  logic [FULL_W-1:0] cnt;
  logic              matchLo, matchHi;

  dct_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .taps(taps), .evtPin(evtPin),
    .cnt(cnt), .outLo(outLo), .outHi(outHi), .matchLo(matchLo),
    .matchHi(matchHi), .st(st), .irqLo(irqLo), .irqHi(irqHi)
  );

  dct_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cnt(cnt), .outLo(outLo),
    .outHi(outHi), .matchLo(matchLo), .matchHi(matchHi)
  );
endmodule

// File: rtl/dct_checker.sv
module dct_checker
  import dct_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input strobe_t           st,
  input logic [FULL_W-1:0] cnt,
  input logic              outLo,
  input logic              outHi,
  input logic              matchLo,
  input logic              matchHi,
  input logic              irqLo,
  input logic              irqHi
);
  p_carry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!st.split && st.tickHi && cnt[BYTE_W-1:0] == '1 && !matchHi
     && !st.wrCntLo && !st.wrCntHi)
    |=> cnt[FULL_W-1:BYTE_W] == $past(cnt[FULL_W-1:BYTE_W]) + 8'd1);

  p_lo_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!st.split && !st.presetLo) |=> $stable(outLo));

  p_indep_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.split && !st.tickHi && !st.wrCntHi) |=> $stable(cnt[FULL_W-1:BYTE_W]));

  p_lo_toggle_r5: assert property (@(posedge clk) disable iff (!rstN)
    matchLo |=> (outLo != $past(outLo)));

  // R3 and R5 share the high output
  p_hi_toggle_r5: assert property (@(posedge clk) disable iff (!rstN)
    matchHi |=> (outHi != $past(outHi)));

  p_clear_lo_r6: assert property (@(posedge clk) disable iff (!rstN)
    (matchLo && st.clrLo && !st.wrCntLo) |=> cnt[BYTE_W-1:0] == '0);

  p_flag_lo_r10: assert property (@(posedge clk) disable iff (!rstN)
    matchLo |=> irqLo);

  p_flag_hi_r10: assert property (@(posedge clk) disable iff (!rstN)
    matchHi |=> irqHi);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!st.tickLo && !st.tickHi && !st.wrCntLo && !st.wrCntHi) |=> $stable(cnt));
endmodule

bind dct_timer dct_checker u_chk (
  .clk(clk), .rstN(rstN), .st(st), .cnt(cnt), .outLo(outLo), .outHi(outHi),
  .matchLo(matchLo), .matchHi(matchHi), .irqLo(irqLo), .irqHi(irqHi)
);

// File: tb/dct_timer_test.sv
module dct_timer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [3:0] taps = 4'b0001;
  logic       evtPin = 1'b0;
  logic       outLo, outHi, irqLo, irqHi;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  localparam logic [2:0] A_CTRL = 3'd0, A_CSEL = 3'd1, A_CNTL = 3'd2, A_CNTH = 3'd3,
                         A_CMPL = 3'd4, A_CMPH = 3'd5, A_OUT = 3'd6, A_FLAG = 3'd7;

  always #2 clk = ~clk;

  dct_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .taps(taps), .evtPin(evtPin),
    .outLo(outLo), .outHi(outHi), .irqLo(irqLo), .irqHi(irqHi)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // run for exactly n ticks of an every-cycle source
  task automatic runFor(input logic [7:0] ctrl, input int n);
    wr(A_CTRL, ctrl);
    repeat (n - 1) @(negedge clk);
    wr(A_CTRL, ctrl & 8'hF9);
  endtask

  task automatic setCnt(input logic [7:0] hi, input logic [7:0] lo);
    wr(A_CNTL, lo);
    wr(A_CNTH, hi);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_CTRL, d); check("R1", "ctrl", d, 8'h00);
    rd(A_CSEL, d); check("R1", "csel", d, 8'h00);
    rd(A_CNTL, d); check("R1", "cnt lo", d, 8'h00);
    rd(A_CNTH, d); check("R1", "cnt hi", d, 8'h00);
    rd(A_CMPL, d); check("R1", "cmp lo", d, 8'hFF);
    rd(A_CMPH, d); check("R1", "cmp hi", d, 8'hFF);
    rd(A_OUT, d);  check("R1", "out reg", d, 8'h00);
    rd(A_FLAG, d); check("R1", "flags", d, 8'h00);
    check("R1", "pins", {outHi, outLo, irqHi, irqLo}, 0);
    taps = 4'b1111;
    idle(5);
    rd(A_CNTL, d); check("R12", "stopped lo", d, 8'h00);
    taps = 4'b0001;
  endtask

  task automatic t_count16();
    logic [7:0] d;
    wr(A_CSEL, 8'h00);
    setCnt(8'h00, 8'hFE);
    runFor(8'h04, 5);
    rd(A_CNTL, d); check("R2", "carry lo", d, 8'h03);
    rd(A_CNTH, d); check("R2", "carry hi", d, 8'h01);
    idle(4);
    rd(A_CNTL, d); check("R12", "hold after stop", d, 8'h03);
    check("R2", "no match irqHi", irqHi, 0);
  endtask

  task automatic t_match16();
    logic [7:0] d;
    wr(A_CMPL, 8'h05); wr(A_CMPH, 8'h01);
    setCnt(8'h01, 8'h00);
    runFor(8'h04, 5);
    check("R3", "outHi toggled", outHi, 1);
    check("R3", "outLo held", outLo, 0);
    rd(A_FLAG, d); check("R3", "flag hi", d, 8'h02);
    runFor(8'h04, 2);
    rd(A_CNTL, d); check("R3", "passes compare", d, 8'h07);
    check("R3", "single toggle", outHi, 1);
    // clear-on-match in combined mode
    wr(A_FLAG, 8'h03);
    wr(A_CMPL, 8'h03); wr(A_CMPH, 8'h00);
    setCnt(8'h00, 8'h00);
    runFor(8'h14, 7);
    rd(A_CNTL, d); check("R6", "16-bit clear lo", d, 8'h01);
    rd(A_CNTH, d); check("R6", "16-bit clear hi", d, 8'h00);
    check("R6", "two toggles", outHi, 1);
    check("R6", "flag", irqHi, 1);
  endtask

  task automatic t_split();
    logic [7:0] d;
    wr(A_FLAG, 8'h03);
    wr(A_CTRL, 8'h01);
    wr(A_CSEL, 8'h10);
    taps = 4'b0001;
    setCnt(8'h10, 8'hFE);
    wr(A_CMPL, 8'h02); wr(A_CMPH, 8'h12);
    runFor(8'h07, 6);
    rd(A_CNTL, d); check("R4", "lo wraps", d, 8'h04);
    rd(A_CNTH, d); check("R4", "hi untouched", d, 8'h10);
    check("R5", "outLo toggled", outLo, 1);
    check("R5", "outHi unchanged", outHi, 1);
    check("R5", "irqLo", irqLo, 1);
    check("R5", "irqHi clear", irqHi, 0);
    taps = 4'b0010;
    runFor(8'h07, 3);
    rd(A_CNTH, d); check("R4", "hi own clock", d, 8'h13);
    rd(A_CNTL, d); check("R4", "lo own clock", d, 8'h04);
    check("R5", "outHi toggled", outHi, 0);
    check("R5", "irqHi", irqHi, 1);
    // clear-on-match in split mode
    taps = 4'b0001;
    wr(A_FLAG, 8'h03);
    wr(A_CNTL, 8'h00);
    runFor(8'h0B, 5);
    rd(A_CNTL, d); check("R6", "split clear lo", d, 8'h01);
    check("R6", "two lo toggles", outLo, 1);
  endtask

  task automatic t_clksel();
    logic [7:0] d;
    wr(A_CTRL, 8'h00);
    wr(A_CMPL, 8'hFF); wr(A_CMPH, 8'hFF);
    wr(A_CSEL, 8'h20);
    setCnt(8'h00, 8'h00);
    taps = 4'b1011;
    runFor(8'h04, 6);
    rd(A_CNTL, d); check("R7", "tap2 idle", d, 8'h00);
    taps = 4'b0100;
    runFor(8'h04, 6);
    rd(A_CNTL, d); check("R7", "tap2 count", d, 8'h06);
    wr(A_CSEL, 8'h40);
    taps = 4'b1111;
    setCnt(8'h00, 8'h00);
    wr(A_CTRL, 8'h04);
    for (int i = 0; i < 3; i++) begin
      evtPin = 1'b1; idle(3);
      evtPin = 1'b0; idle(3);
    end
    idle(4);
    wr(A_CTRL, 8'h00);
    rd(A_CNTL, d); check("R7", "event edges", d, 8'h03);
    taps = 4'b0001;
  endtask

  task automatic t_read();
    logic [7:0] d;
    wr(A_CSEL, 8'h00);
    setCnt(8'h12, 8'hFE);
    wr(A_CTRL, 8'h04);
    rd(A_CNTL, d); check("R8", "low read", d, 8'hFE);
    idle(1);
    rd(A_CNTH, d); check("R8", "captured high", d, 8'h12);
    wr(A_CTRL, 8'h00);
    rd(A_CNTL, d); check("R8", "low after stop", d, 8'h02);
    rd(A_CNTH, d); check("R8", "high after stop", d, 8'h13);
    wr(A_CTRL, 8'h01);
    wr(A_CNTH, 8'h55);
    rd(A_CNTH, d); check("R8", "split live high", d, 8'h55);
  endtask

  task automatic t_preset();
    logic [7:0] d;
    taps = 4'b0000;
    wr(A_CTRL, 8'h01);
    wr(A_OUT, 8'h00);
    check("R9", "both cleared", {outHi, outLo}, 0);
    wr(A_CTRL, 8'h05);
    wr(A_OUT, 8'h03);
    check("R9", "lo preset", outLo, 1);
    check("R9", "hi running ignored", outHi, 0);
    rd(A_OUT, d); check("R9", "out reg", d, 8'h01);
    wr(A_CTRL, 8'h00);
    wr(A_OUT, 8'h02);
    check("R9", "16-bit preset", {outHi, outLo}, 2);
    taps = 4'b0001;
  endtask

  task automatic t_flags();
    logic [7:0] d;
    wr(A_CTRL, 8'h01);
    wr(A_CSEL, 8'h00);
    setCnt(8'h00, 8'h00);
    wr(A_CMPL, 8'h01); wr(A_CMPH, 8'h01);
    wr(A_FLAG, 8'h03);
    runFor(8'h07, 1);
    rd(A_FLAG, d); check("R10", "both set", d, 8'h03);
    wr(A_FLAG, 8'h01);
    rd(A_FLAG, d); check("R10", "clear lo only", d, 8'h02);
    check("R10", "irq pins", {irqHi, irqLo}, 2);
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, d); check("R10", "zero write", d, 8'h02);
    wr(A_FLAG, 8'h02);
    rd(A_FLAG, d); check("R10", "clear hi", d, 8'h00);
  endtask

  task automatic t_wrprio();
    logic [7:0] d;
    wr(A_CTRL, 8'h00);
    wr(A_CMPL, 8'hFF); wr(A_CMPH, 8'hFF);
    setCnt(8'h00, 8'h00);
    wr(A_CTRL, 8'h04);
    idle(3);
    wr(A_CNTL, 8'h40);
    rd(A_CNTL, d); check("R11", "write wins", d, 8'h40);
    wr(A_CTRL, 8'h00);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    t_reset();
    t_count16();
    t_match16();
    t_split();
    t_clksel();
    t_read();
    t_preset();
    t_flags();
    t_wrprio();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule